// File: doc/BRIEF.md
# Composite Sync and Display Window Generator

This block times a 625-line television raster from a single fast clock. A line is 1728 clock cycles at 27 MHz, which is 64 µs. A cycle counter runs within the line. A half-line counter runs within the field. From these two counters the block builds an active-low composite sync. Ordinary lines carry a single line-sync pulse. Around each field boundary the sync changes to five equalizing half-lines, then five broad half-lines, then five more equalizing half-lines. The block also produces a display-enable window that covers forty character cells of each line over a fixed band of lines, and an odd/even flag that changes at every field start.

A two-bit raster mode sets the field length. The options are interlaced (312.5 lines per field), non-interlaced with fields of 312 and 313 lines in turn, non-interlaced with every field 312 lines, and scan-locked. In scan-locked mode the rising edges of external line and field flyback inputs restart the line and the field. A newsflash/subtitle input pushes both non-interlaced modes back to interlaced. A disable input holds the odd/even flag low.

Top module: `csync_gen`

## Requirements
- R1: After reset the raster is at cycle 0 of half-line 0 of a field. At that point `csync_n` is 0 (the start of a broad pulse), `disp_en` is 0 and `odd_even` is 0.
- R2: On half-lines 10 and later of a field, outside the last five half-lines, `csync_n` is 0 only during the first SYNC_W cycles of each line. At the defaults this is 126 cycles.
- R3: On half-lines 5 to 9 and on the last five half-lines of a field, `csync_n` is 0 during the first EQ_W cycles of every half-line (63 by default) and 1 for the rest of the half-line.
- R4: On half-lines 0 to 4 of a field, `csync_n` is 0 during the first BROAD_W cycles of every half-line (738 by default) and 1 for the rest of the half-line.
- R5: `mode_sel` sets the field length in half-lines, with FL = FIELD_LINES (312). The values are: 00 gives 2·FL+1 for every field; 01 gives 2·FL for a field whose `odd_even` state is 0 and 2·FL+2 for a field whose state is 1; 10 gives 2·FL for every field; 11 is scan-locked and runs free at 2·FL+1.
- R6: While `news_force` is 1, modes 01 and 10 behave exactly as mode 00.
- R7: `disp_en` is 1 only when both of these hold: the line cycle is within [HDE_START, HDE_START+HDE_LEN-1] (450 to 1529 by default), and the line number within the field is within [VDE_FIRST, VDE_LAST] (42 to 291). Line 1 is the line that holds the field start, and the number goes up at each later line start.
- R8: The internal field parity is 0 after reset and inverts at each field start. `odd_even` shows this parity.
- R9: While `oe_disable` is 1, `odd_even` is 0. The parity keeps running underneath, so after release `odd_even` shows the same value it would have shown with no disable.
- R10: In mode 11, a rising edge on `lfb_in` makes the next cycle cycle 0 of a new line and advances the half-line count. A rising edge on `ffb_in` makes the next cycle half-line 0 and line 1 of a new field and inverts the parity.
- R11: In modes 00, 01 and 10, `lfb_in` and `ffb_in` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raster clock, 27 MHz at the default parameters |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Raster mode: 00 interlaced, 01 312/313, 10 312/312, 11 scan-locked |
| news_force | input | 1 | Newsflash/subtitle shown; forces the non-interlaced modes to interlaced |
| lfb_in | input | 1 | Line flyback pulse, active high, used in scan-locked mode |
| ffb_in | input | 1 | Field flyback pulse, active high, used in scan-locked mode |
| oe_disable | input | 1 | Holds `odd_even` low |
| csync_n | output | 1 | Composite sync, low during a pulse |
| disp_en | output | 1 | Text display window |
| odd_even | output | 1 | Field parity flag |

## Verification
Some properties are checked by assertions on every cycle:
- a flyback edge in scan-locked mode restarts the line or the field on the next cycle;
- flyback inputs in the other modes leave the cycle count running;
- the half-line count stays within the longest field;
- parity inverts at every field start;
- each sync-region half-line begins with a low pulse;
- the display window opens only at its first cycle and never overlaps sync.

Other behaviour can only be shown by the bench scenarios: the exact field lengths of each mode, the placement of equalizing and broad pulses, the numbering of lines for the vertical window across fields that start mid-line, and the masking of the odd/even flag. The bench sweeps whole fields of a reduced raster and compares every output on every cycle against values computed arithmetically from the cycle count.

// File: rtl/csg_pkg.sv
package csg_pkg;

    // Raster field-length modes selected by the two control bits
    typedef enum logic [1:0] {
        RM_INTERLACE = 2'b00,
        RM_NI_LONG   = 2'b01,
        RM_NI_SHORT  = 2'b10,
        RM_SCAN      = 2'b11
    } raster_mode_e;

    // Kind of sync pulse carried by a half-line
    typedef enum logic [1:0] {
        PK_LINE  = 2'd0,
        PK_EQ    = 2'd1,
        PK_BROAD = 2'd2
    } pulse_kind_e;

    // Half-lines per group in the field sync region (equalize, broad, equalize)
    localparam int unsigned SYNC_GROUP_HL = 5;

endpackage

// File: rtl/csg_timebase.sv
module csg_timebase
    import csg_pkg::*;
#(
    parameter  int unsigned LINE_CYC    = 1728,
    parameter  int unsigned FIELD_LINES = 312,
    localparam int unsigned CYC_W       = $clog2(LINE_CYC),
    localparam int unsigned HL_W        = $clog2(2 * FIELD_LINES + 3),
    localparam int unsigned LN_W        = $clog2(FIELD_LINES + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  raster_mode_e      mode,
    input  logic              news_force,
    input  logic              lfb_in,
    input  logic              ffb_in,
    output logic [CYC_W-1:0]  cyc_o,
    output logic [HL_W-1:0]   hl_o,
    output logic [HL_W-1:0]   fld_len_o,
    output logic [LN_W-1:0]   ln_o,
    output logic              parity_o
);

    localparam int unsigned HALF = LINE_CYC / 2;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [HL_W-1:0]  hl;
        logic [LN_W-1:0]  ln;
        logic             parity;
        logic             lfb_prev;
        logic             ffb_prev;
    } tb_state_t;

    tb_state_t    s_q, s_d;
    raster_mode_e eff_mode;
    logic [HL_W-1:0] fld_len;
    logic scan, lfb_rise, ffb_rise, line_end, half_end, hl_bnd, hl_last, fs_evt;

    // Newsflash/subtitle display pulls the non-interlaced modes back to interlace
    always_comb begin
        eff_mode = mode;
        if (news_force && (mode == RM_NI_LONG || mode == RM_NI_SHORT)) begin
            eff_mode = RM_INTERLACE;
        end
    end

    always_comb begin
        unique case (eff_mode)
            RM_NI_LONG:  fld_len = s_q.parity ? HL_W'(2 * FIELD_LINES + 2)
                                              : HL_W'(2 * FIELD_LINES);
            RM_NI_SHORT: fld_len = HL_W'(2 * FIELD_LINES);
            default:     fld_len = HL_W'(2 * FIELD_LINES + 1);
        endcase
    end

    always_comb begin
        scan     = (eff_mode == RM_SCAN);
        lfb_rise = scan && lfb_in && !s_q.lfb_prev;
        ffb_rise = scan && ffb_in && !s_q.ffb_prev;
        line_end = (s_q.cyc == CYC_W'(LINE_CYC - 1));
        half_end = (s_q.cyc == CYC_W'(HALF - 1));
        hl_bnd   = line_end || half_end || lfb_rise;
        hl_last  = (s_q.hl >= fld_len - 1'b1);
        fs_evt   = ffb_rise || (hl_bnd && hl_last);

        s_d          = s_q;
        s_d.lfb_prev = lfb_in;
        s_d.ffb_prev = ffb_in;
        s_d.cyc      = (line_end || lfb_rise) ? '0 : s_q.cyc + 1'b1;
        if (fs_evt) begin
            s_d.hl     = '0;
            s_d.ln     = LN_W'(1);
            s_d.parity = ~s_q.parity;
        end else begin
            if (hl_bnd) begin
                s_d.hl = s_q.hl + 1'b1;
            end
            if (line_end || lfb_rise) begin
                s_d.ln = s_q.ln + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cyc: '0, hl: '0, ln: LN_W'(1), parity: 1'b0,
                     lfb_prev: 1'b0, ffb_prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc_o     = s_q.cyc;
    assign hl_o      = s_q.hl;
    assign fld_len_o = fld_len;
    assign ln_o      = s_q.ln;
    assign parity_o  = s_q.parity;

    AST_LFB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_SCAN && lfb_in && !s_q.lfb_prev) |=> (s_q.cyc == '0))
        else $error("line flyback did not restart the line"); // R10
    AST_FFB_NEW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_SCAN && ffb_in && !s_q.ffb_prev) |=> (s_q.hl == '0 && s_q.ln == LN_W'(1)))
        else $error("field flyback did not start a field"); // R10
    AST_FLYBACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != RM_SCAN && lfb_in && !line_end) |=> (s_q.cyc == CYC_W'($past(s_q.cyc) + 1'b1)))
        else $error("flyback disturbed free-running line"); // R11
    AST_HL_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hl <= HL_W'(2 * FIELD_LINES + 1))
        else $error("half-line count beyond longest field"); // R5
    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        fs_evt |=> (s_q.parity != $past(s_q.parity)))
        else $error("parity did not invert at field start"); // R8

endmodule

// File: rtl/csg_pulse_shaper.sv
module csg_pulse_shaper
    import csg_pkg::*;
#(
    parameter  int unsigned LINE_CYC    = 1728,
    parameter  int unsigned FIELD_LINES = 312,
    parameter  int unsigned SYNC_W      = 126,
    parameter  int unsigned EQ_W        = 63,
    parameter  int unsigned BROAD_W     = 738,
    localparam int unsigned CYC_W       = $clog2(LINE_CYC),
    localparam int unsigned HL_W        = $clog2(2 * FIELD_LINES + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cyc,
    input  logic [HL_W-1:0]   hl,
    input  logic [HL_W-1:0]   fld_len,
    output logic              csync_n
);

    localparam int unsigned HALF = LINE_CYC / 2;

    logic [CYC_W-1:0] hpos;
    pulse_kind_e      kind;

    always_comb begin
        hpos = (cyc >= CYC_W'(HALF)) ? cyc - CYC_W'(HALF) : cyc;

        // Region order: pre-equalize at field end, broad, post-equalize, ordinary lines
        if (hl >= fld_len - HL_W'(SYNC_GROUP_HL)) begin
            kind = PK_EQ;
        end else if (hl < HL_W'(SYNC_GROUP_HL)) begin
            kind = PK_BROAD;
        end else if (hl < HL_W'(2 * SYNC_GROUP_HL)) begin
            kind = PK_EQ;
        end else begin
            kind = PK_LINE;
        end

        unique case (kind)
            PK_EQ:    csync_n = !(hpos < CYC_W'(EQ_W));
            PK_BROAD: csync_n = !(hpos < CYC_W'(BROAD_W));
            default:  csync_n = !(cyc < CYC_W'(SYNC_W));
        endcase
    end

    AST_REGION_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == '0 && hl < HL_W'(2 * SYNC_GROUP_HL)) |-> !csync_n)
        else $error("sync-region half-line without leading pulse"); // R4

endmodule

// File: rtl/csg_window.sv
module csg_window #(
    parameter  int unsigned LINE_CYC    = 1728,
    parameter  int unsigned FIELD_LINES = 312,
    parameter  int unsigned HDE_START   = 450,
    parameter  int unsigned HDE_LEN     = 1080,
    parameter  int unsigned VDE_FIRST   = 42,
    parameter  int unsigned VDE_LAST    = 291,
    localparam int unsigned CYC_W       = $clog2(LINE_CYC),
    localparam int unsigned LN_W        = $clog2(FIELD_LINES + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cyc,
    input  logic [LN_W-1:0]   ln,
    output logic              disp_en
);

    logic h_act, v_act;

    always_comb begin
        h_act   = (cyc >= CYC_W'(HDE_START)) && (cyc < CYC_W'(HDE_START + HDE_LEN));
        v_act   = (ln >= LN_W'(VDE_FIRST)) && (ln <= LN_W'(VDE_LAST));
        disp_en = h_act && v_act;
    end

    AST_WINDOW_OPENS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en) |-> (cyc == CYC_W'(HDE_START)))
        else $error("display window opened off its first cycle"); // R7

endmodule

// File: rtl/csync_gen.sv
module csync_gen
    import csg_pkg::*;
#(
    parameter  int unsigned LINE_CYC    = 1728,
    parameter  int unsigned FIELD_LINES = 312,
    parameter  int unsigned SYNC_W      = 126,
    parameter  int unsigned EQ_W        = 63,
    parameter  int unsigned BROAD_W     = 738,
    parameter  int unsigned HDE_START   = 450,
    parameter  int unsigned HDE_LEN     = 1080,
    parameter  int unsigned VDE_FIRST   = 42,
    parameter  int unsigned VDE_LAST    = 291
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       news_force,
    input  logic       lfb_in,
    input  logic       ffb_in,
    input  logic       oe_disable,
    output logic       csync_n,
    output logic       disp_en,
    output logic       odd_even
);

    localparam int unsigned CYC_W = $clog2(LINE_CYC);
    localparam int unsigned HL_W  = $clog2(2 * FIELD_LINES + 3);
    localparam int unsigned LN_W  = $clog2(FIELD_LINES + 3);

    raster_mode_e     mode_e;
    logic [CYC_W-1:0] cyc;
    logic [HL_W-1:0]  hl;
    logic [HL_W-1:0]  fld_len;
    logic [LN_W-1:0]  ln;
    logic             parity;

    assign mode_e = raster_mode_e'(mode_sel);

    csg_timebase #(
        .LINE_CYC    (LINE_CYC),
        .FIELD_LINES (FIELD_LINES)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_e),
        .news_force (news_force),
        .lfb_in     (lfb_in),
        .ffb_in     (ffb_in),
        .cyc_o      (cyc),
        .hl_o       (hl),
        .fld_len_o  (fld_len),
        .ln_o       (ln),
        .parity_o   (parity)
    );

    csg_pulse_shaper #(
        .LINE_CYC    (LINE_CYC),
        .FIELD_LINES (FIELD_LINES),
        .SYNC_W      (SYNC_W),
        .EQ_W        (EQ_W),
        .BROAD_W     (BROAD_W)
    ) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (cyc),
        .hl      (hl),
        .fld_len (fld_len),
        .csync_n (csync_n)
    );

    csg_window #(
        .LINE_CYC    (LINE_CYC),
        .FIELD_LINES (FIELD_LINES),
        .HDE_START   (HDE_START),
        .HDE_LEN     (HDE_LEN),
        .VDE_FIRST   (VDE_FIRST),
        .VDE_LAST    (VDE_LAST)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (cyc),
        .ln      (ln),
        .disp_en (disp_en)
    );

    // Parity keeps running while the flag is masked
    assign odd_even = parity & ~oe_disable;

    AST_WINDOW_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> csync_n)
        else $error("display window overlaps a sync pulse"); // R7

endmodule

// File: tb/tb_csync_gen.sv
module tb_csync_gen;

    localparam int CLK_PERIOD = 10;
    localparam int LINE  = 40;
    localparam int HALF  = LINE / 2;
    localparam int FL    = 20;
    localparam int SYNCW = 3;
    localparam int EQW   = 2;
    localparam int BRW   = 17;
    localparam int HDS   = 10;
    localparam int HDL   = 24;
    localparam int VF    = 13;
    localparam int VL    = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       news_force = 1'b0;
    logic       lfb_in = 1'b0;
    logic       ffb_in = 1'b0;
    logic       oe_disable = 1'b0;
    logic       csync_n, disp_en, odd_even;

    int n_cmp = 0;
    int n_bad = 0;

    csync_gen #(
        .LINE_CYC (LINE), .FIELD_LINES (FL), .SYNC_W (SYNCW), .EQ_W (EQW),
        .BROAD_W (BRW), .HDE_START (HDS), .HDE_LEN (HDL),
        .VDE_FIRST (VF), .VDE_LAST (VL)
    ) dut (
        .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .news_force (news_force),
        .lfb_in (lfb_in), .ffb_in (ffb_in), .oe_disable (oe_disable),
        .csync_n (csync_n), .disp_en (disp_en), .odd_even (odd_even)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what, input logic got,
                         input logic exp, input int k);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s k=%0d actual=%0d expected=%0d", req, what, k, got, exp);
        end
    endtask

    // Arithmetic reference: eff 0 interlaced, 1 = 312/313, 2 = 312/312
    function automatic void model(input int eff, input int k, output logic cs_n,
                                  output logic de, output logic par, output string tag);
        int h, cyc, hl, f, len, fsh, ln, hpos, pl, p;
        h   = k / HALF;
        cyc = k % LINE;
        if (eff == 1) begin
            pl = 4 * FL + 2;
            p  = h % pl;
            if (p < 2 * FL) begin
                hl = p; f = 2 * (h / pl); len = 2 * FL;
            end else begin
                hl = p - 2 * FL; f = 2 * (h / pl) + 1; len = 2 * FL + 2;
            end
        end else begin
            len = (eff == 2) ? 2 * FL : 2 * FL + 1;
            hl  = h % len;
            f   = h / len;
        end
        fsh  = h - hl;
        ln   = 1 + k / LINE - (fsh * HALF) / LINE;
        hpos = cyc % HALF;
        if (hl >= len - 5 || (hl >= 5 && hl < 10)) begin
            cs_n = !(hpos < EQW); tag = "R3";
        end else if (hl < 5) begin
            cs_n = !(hpos < BRW); tag = "R4";
        end else begin
            cs_n = !(cyc < SYNCW); tag = "R2";
        end
        de  = (cyc >= HDS) && (cyc < HDS + HDL) && (ln >= VF) && (ln <= VL);
        par = f[0];
    endfunction

    task automatic do_reset(input logic [1:0] m, input logic nf);
        rst_n = 1'b0; mode_sel = m; news_force = nf;
        lfb_in = 1'b0; ffb_in = 1'b0; oe_disable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sweep(input logic [1:0] m, input logic nf, input int eff, input int n,
                         input string tag, input int dis_lo, input int dis_hi,
                         input int glitch_at);
        logic e_cs, e_de, e_par;
        string ctag, t;
        do_reset(m, nf);
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            oe_disable = (k >= dis_lo) && (k < dis_hi);
            lfb_in = (glitch_at >= 0) && (k >= glitch_at) && (k < glitch_at + 3);
            ffb_in = (glitch_at >= 0) && (k >= glitch_at + 1) && (k < glitch_at + 4);
            #1;
            model(eff, k, e_cs, e_de, e_par, ctag);
            t = {tag, "/", ctag};
            if (glitch_at >= 0 && k > glitch_at && k <= glitch_at + 60) t = "R11";
            check(t, "csync_n", csync_n, e_cs, k);
            check((t == "R11") ? "R11" : "R7", "disp_en", disp_en, e_de, k);
            check(oe_disable ? "R9" : "R8", "odd_even", odd_even, e_par & !oe_disable, k);
        end
        lfb_in = 1'b0; ffb_in = 1'b0; oe_disable = 1'b0;
    endtask

    task automatic scan_test();
        localparam int K0 = 330;
        localparam int KL = 565;
        logic e_cs, e_de, e_par;
        string ctag;
        do_reset(2'b11, 1'b0);
        for (int k = 0; k <= 600; k++) begin
            if (k > 0) @(negedge clk);
            ffb_in = (k == K0);
            lfb_in = (k == KL);
            #1;
            if (k <= K0) begin
                model(0, k, e_cs, e_de, e_par, ctag);
                check({"R5/", ctag}, "csync_n", csync_n, e_cs, k);
                check("R8", "odd_even", odd_even, e_par, k);
            end
            if (k == K0 + 1) begin
                check("R10", "odd_even after field flyback", odd_even, 1'b1, k);
                check("R10", "broad pulse after field flyback", csync_n, 1'b0, k);
            end
            if (k == K0 + 10) check("R10", "second broad half-line start", csync_n, 1'b0, k);
            if (k == K0 + 27) check("R10", "broad pulse end", csync_n, 1'b1, k);
            if (k == 560) check("R2", "line sync before line flyback", csync_n, 1'b0, k);
            if (k == KL + 1) check("R10", "line sync after line flyback", csync_n, 1'b0, k);
            if (k == KL + 1 + SYNCW) check("R10", "line sync end after flyback", csync_n, 1'b1, k);
        end
        lfb_in = 1'b0; ffb_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset(2'b00, 1'b0);
        #1;
        check("R1", "csync_n at reset", csync_n, 1'b0, 0);
        check("R1", "disp_en at reset", disp_en, 1'b0, 0);
        check("R1", "odd_even at reset", odd_even, 1'b0, 0);

        // Interlaced, with a masked stretch and flyback glitches that must be ignored
        sweep(2'b00, 1'b0, 0, 2700, "R5", 1800, 2200, 500);
        // 312/313 alternating fields
        sweep(2'b01, 1'b0, 1, 3400, "R5", -1, -1, -1);
        // 312/312 fields, with flyback glitches
        sweep(2'b10, 1'b0, 2, 2500, "R5", -1, -1, 900);
        // Newsflash forces interlace in both non-interlaced modes
        sweep(2'b01, 1'b1, 0, 2000, "R6", -1, -1, -1);
        sweep(2'b10, 1'b1, 0, 1800, "R6", -1, -1, -1);
        // Scan-locked flyback following
        scan_test();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule